// File: doc/BRIEF.md
# Counting-ramp conversion sequencer

This block runs a stair-step counting conversion against an external digital-to-analog converter and a single comparator. It presents a code to the converter, starting at zero, and raises that code by one step at a time as long as the comparator reports that the analog input is still above the converter's output. When the comparator reports that the staircase has caught up, the block copies the step count into its result register, pulses a one-cycle completion strobe and drops the code back to zero. The next conversion then begins with no command from outside.

The comparator input is asynchronous and passes through a configurable flop synchronizer. The converter and comparator together may add a fixed number of cycles of delay (`DAC_LAT_CYC`). After each code change the block waits until the comparator response to the new code has passed through the whole path before it samples it. A conversion therefore takes a number of cycles that depends on the data: `(result + 1) * STEP_CYC`, where `STEP_CYC = SYNC_STAGES + DAC_LAT_CYC + 1`. When the code reaches all ones while the comparator is still high, the conversion ends at full scale and the code does not wrap.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While `rst_n` is low, `dac_code`, `result` and `done` are all zero.
- R2: Every conversion starts with `dac_code` at zero. The code changes only by exactly +1, or by a return to zero when a conversion ends.
- R3: The synchronized comparator is sampled once per step, `STEP_CYC` cycles after the last code change (3 cycles with the defaults). `dac_code` moves to its next value only at those instants.
- R4: When the sampled comparator is low, `result` takes the present `dac_code` value, `done` is 1 for that cycle, and `dac_code` returns to zero on the same clock edge.
- R5: Between `done` pulses, `result` holds its value unchanged.
- R6: `done` is high for exactly one cycle per conversion.
- R7: When `dac_code` is all ones (2^N−1) and the sampled comparator is still high, the conversion ends with `result` all ones and `dac_code` back to zero. The code never wraps to zero by counting.
- R8: A conversion that yields the value r lasts exactly (r+1)·`STEP_CYC` cycles, from its start to its `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_in | input | 1 | Asynchronous comparator: 1 while the analog input exceeds the converter output |
| dac_code | output | CODE_W | Staircase code driven to the external converter |
| result | output | CODE_W | Latched result of the last finished conversion |
| done | output | 1 | One-cycle strobe marking each update of `result` |

## Verification
On every cycle the assertions check the shape of the code sequence: it moves only by single up-steps or by a return to zero, and it never wraps past all ones. They also check that code steps fall only when the settle timer has expired, that `done` is one cycle wide and coincides with a code of zero, and that `result` holds between strobes. How long each conversion lasts, and whether the latched value equals the number of steps to the input level, can only be seen in the bench's scenarios. The bench runs a modeled converter-comparator loop with input levels from zero through mid-scale, near full scale and beyond full scale, and predicts the code and strobe on every cycle.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

   typedef enum logic [1:0] {
      DEC_WAIT = 2'd0,
      DEC_STEP = 2'd1,
      DEC_STOP = 2'd2,
      DEC_FULL = 2'd3
   } ramp_dec_e;

   function automatic int unsigned step_cycles(input int unsigned sync_stages,
                                               input int unsigned dac_lat);
      return sync_stages + dac_lat + 1;
   endfunction

endpackage

// File: rtl/ramp_sync.sv
module ramp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("ramp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else if (i == 0) chain[i] <= d;
            else chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ramp_settle_timer.sv
module ramp_settle_timer #(
   parameter int unsigned WAIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expired
);
   localparam int unsigned TW = (WAIT < 1) ? 1 : $clog2(WAIT + 1);
   localparam logic [TW-1:0] LOAD = TW'(WAIT);

   generate
      if (WAIT < 1) begin : g_bad
         $error("ramp_settle_timer: WAIT must be at least 1");
      end
   endgenerate

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= LOAD;
      else if (restart) cnt <= LOAD;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   p_timer_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == LOAD));
endmodule

// File: rtl/ramp_step_counter.sv
module ramp_step_counter #(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              clr,
   output logic [CODE_W-1:0] code,
   output logic              at_max
);
   localparam logic [CODE_W-1:0] MAX_CODE = {CODE_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code <= '0;
      else if (clr) code <= '0;
      else if (inc && code != MAX_CODE) code <= code + 1'b1;
   end

   assign at_max = (code == MAX_CODE);

   p_code_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (code != $past(code)) |-> (code == '0 || code == $past(code) + 1'b1));

   p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (code == MAX_CODE) |=> (code == MAX_CODE || code == '0));
endmodule

// File: rtl/ramp_result_latch.sv
module ramp_result_latch #(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] d,
   output logic [CODE_W-1:0] q,
   output logic              strobe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= load;
         if (load) q <= d;
      end
   end

   p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |-> (q == $past(q)));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
   import ramp_adc_pkg::*;
#(
   parameter int unsigned CODE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DAC_LAT_CYC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              comp_in,
   output logic [CODE_W-1:0] dac_code,
   output logic [CODE_W-1:0] result,
   output logic              done
);
   localparam int unsigned STEP_CYC = step_cycles(SYNC_STAGES, DAC_LAT_CYC);
   localparam int unsigned WAIT     = STEP_CYC - 1;

   generate
      if (CODE_W < 1 || CODE_W > 24) begin : g_bad_w
         $error("ramp_adc_ctrl: CODE_W out of range 1..24");
      end
      if (SYNC_STAGES < 2) begin : g_bad_s
         $error("ramp_adc_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic      comp_s;
   logic      settled;
   logic      at_max;
   logic      code_inc;
   logic      code_clr;
   ramp_dec_e dec;

   ramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (comp_in),
      .q    (comp_s)
   );

   ramp_settle_timer #(.WAIT(WAIT)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(settled),
      .expired(settled)
   );

   always_comb begin
      if (!settled)     dec = DEC_WAIT;
      else if (!comp_s) dec = DEC_STOP;
      else if (at_max)  dec = DEC_FULL;
      else              dec = DEC_STEP;
   end

   assign code_inc = (dec == DEC_STEP);
   assign code_clr = (dec == DEC_STOP) || (dec == DEC_FULL);

   ramp_step_counter #(.CODE_W(CODE_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (code_inc),
      .clr   (code_clr),
      .code  (dac_code),
      .at_max(at_max)
   );

   ramp_result_latch #(.CODE_W(CODE_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (code_clr),
      .d     (dac_code),
      .q     (result),
      .strobe(done)
   );

   p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (dac_code == '0));

   p_step_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_code != $past(dac_code)) |-> $past(settled));

   p_full_scale_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && comp_s && at_max) |=> (done && result == {CODE_W{1'b1}}));
endmodule

// File: tb/ramp_adc_ctrl_bench.sv
module ramp_adc_ctrl_bench;
   localparam int unsigned CODE_W = 8;
   localparam int MAXV  = (1 << CODE_W) - 1;
   localparam int STEP  = 3;
   localparam int NTGT  = 10;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              comp_in;
   logic [CODE_W-1:0] dac_code;
   logic [CODE_W-1:0] result;
   logic              done;

   int target;
   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   // modeled converter + comparator: high while input level is above the code
   assign comp_in = (int'(dac_code) < target);

   ramp_adc_ctrl #(.CODE_W(CODE_W)) u_ramp_adc_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .comp_in (comp_in),
      .dac_code(dac_code),
      .result  (result),
      .done    (done)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int clip(input int t);
      return (t > MAXV) ? MAXV : t;
   endfunction

   initial begin
      int tlist[NTGT] = '{0, 1, 5, 100, 37, 254, 255, 256, 3, 128};
      int idx;
      int c;
      int res;
      int last;
      rst_n  = 1'b0;
      target = 0;
      repeat (3) @(negedge clk);
      check("R1 code in reset",   int'(dac_code), 0);
      check("R1 result in reset", int'(result),   0);
      check("R1 done in reset",   int'(done),     0);
      rst_n  = 1'b1;
      idx    = 0;
      target = tlist[0];
      res    = clip(target);
      last   = 0;
      c      = 0;
      while (idx < NTGT) begin
         @(negedge clk);
         c++;
         if (c == STEP * (res + 1)) begin
            check("R6 done strobe at end (R8 length)", int'(done), 1);
            if (res == MAXV)
               check("R7 full-scale result", int'(result), res);
            else
               check("R4 latched step count", int'(result), res);
            check("R2 code back to zero", int'(dac_code), 0);
            last = res;
            idx++;
            if (idx < NTGT) begin
               target = tlist[idx];
               res    = clip(target);
            end
            c = 0;
         end else begin
            check("R6 no strobe mid-conversion", int'(done), 0);
            check("R3 code on step schedule", int'(dac_code), c / STEP);
            check("R5 result held", int'(result), last);
         end
      end
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule